// File: doc/BRIEF.md
# Nested interrupt acknowledge controller

This block decides, at each instruction boundary of a small processor core, whether a pending interrupt is taken and which one. Maskable sources are latched per line, each with a programmable level bit (high or low) and a mask bit. A single non-maskable input is edge-detected and latched. Acceptance is governed by a global enable flag and an in-service level flag. Every acceptance clears the enable flag, so nesting requires software to set it again. The core signals enable, disable and return events through one-cycle strobes.

On each acceptance the block saves the enable, in-service level and non-maskable-busy flags on a small internal stack. A return pops that stack, so nesting unwinds in order. The block issues a one-cycle acknowledge with the winning index. Vector fetch, saving state to memory and instruction execution are left to the core.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset the enable flag is 0, the in-service level flag is 1, no acknowledge is issued and no request is pending.
- R2: A pulse on a request line latches that source until it is accepted. Acceptance is only decided on a cycle with `boundary_i` high. `ack_o` is then high for exactly the next cycle, with `ack_idx_o` holding the source index and `ack_nmi_o` at 0. The accepted source's latch is cleared.
- R3: A maskable request is accepted only while the enable flag is 1. A refused request stays pending. `ei_i` sets the flag and `di_i` clears it.
- R4: Any acceptance clears the enable flag in the same step.
- R5: A level bit of 0 means high level and 1 means low level. Accepting a maskable source loads the in-service level flag with its level bit.
- R6: With the enable flag at 1, a high-level source is accepted whatever the in-service level flag holds. A low-level source is accepted only while that flag is 1.
- R7: Among eligible sources, high level beats low level, and within one level the lowest index wins.
- R8: A masked source (mask bit 1) takes no part in arbitration but stays latched. It becomes eligible again once its mask bit clears.
- R9: A rising edge on `nmi_i` is latched and accepted at the next boundary, whatever the enable flag holds. It wins over every maskable source. The acknowledge shows `ack_nmi_o`=1 and `ack_idx_o`=0. The enable flag is cleared and the in-service level flag is left unchanged.
- R10: While a non-maskable service is open, nothing is accepted until its return.
- R11: A return restores the enable and in-service level flags saved by the most recent acceptance not yet returned. A return with nothing saved leaves both flags unchanged.
- R12: A boundary that coincides with `reti_i` accepts nothing. The next boundary may accept, so one main-level instruction retires in between.
- R13: While DEPTH acceptances are outstanding, no further request of any kind is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NSRC | Request pulses, one per maskable source |
| prio_i | input | NSRC | Level bit per source, 0 high, 1 low |
| mask_i | input | NSRC | Mask bit per source, 1 hides the source |
| nmi_i | input | 1 | Non-maskable request, edge-detected |
| boundary_i | input | 1 | Instruction boundary strobe |
| ei_i | input | 1 | Enable-interrupt strobe |
| di_i | input | 1 | Disable-interrupt strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| ack_o | output | 1 | One-cycle acknowledge |
| ack_nmi_o | output | 1 | Acknowledge is for the non-maskable source |
| ack_idx_o | output | $clog2(NSRC) | Index of the accepted maskable source |
| ien_o | output | 1 | Current enable flag |
| isp_o | output | 1 | Current in-service level flag |

## Verification
Arbitration is tried in three ways: with several sources of mixed levels raised at once, with a high-level source competing against a lower-index low-level one, and with a masked source whose latch must survive. Together these separate the level ordering from the index ordering. Nesting is tried as a chain of high over high and low under high, then unwound by returns whose restored flags are compared. This catches a stack that restores the wrong entry or pops when empty. Non-maskable sequences send a second edge during service and then fill the stack to its limit. They show whether blocking comes from the service flag or from the depth limit. Returns placed on boundaries with an eligible request pending confirm that the first boundary after a return takes nothing.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;

   typedef struct packed {
      logic nmi;   // non-maskable service open
      logic isp;   // in-service level, 0 = high level being serviced
      logic ien;   // global enable
   } irq_flags_t;

   localparam irq_flags_t FLAGS_RST = '{nmi: 1'b0, isp: 1'b1, ien: 1'b0};

endpackage

// File: rtl/nest_irq_arb.sv
module nest_irq_arb #(
   parameter int unsigned NSRC = 8,
   localparam int unsigned IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NSRC-1:0] cand_hi_i,
   input  logic [NSRC-1:0] cand_lo_i,
   output logic            valid_o,
   output logic [IW-1:0]   idx_o,
   output logic            low_o
);

   logic [NSRC-1:0] pool;

   always_comb begin
      low_o = ~(|cand_hi_i);
      pool  = low_o ? cand_lo_i : cand_hi_i;
      idx_o = '0;
      for (int k = NSRC - 1; k >= 0; k--) begin
         if (pool[k]) idx_o = IW'(k);
      end
   end

   assign valid_o = |pool;

   a_r7_winner_is_candidate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (((low_o ? cand_lo_i : cand_hi_i) >> idx_o) & NSRC'(1)) != '0);

   a_r7_high_before_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && low_o) |-> cand_hi_i == '0);

endmodule

// File: rtl/nest_irq_stack.sv
module nest_irq_stack #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned W = 3,
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         push_i,
   input  logic         pop_i,
   input  logic [W-1:0] data_i,
   output logic [W-1:0] top_o,
   output logic         full_o,
   output logic         empty_o
);

   if (DEPTH < 2 || DEPTH > 64) begin : g_bad_depth
      $error("nest_irq_stack: DEPTH must lie in 2..64");
   end

   logic [W-1:0]  mem_q [DEPTH];
   logic [CW-1:0] cnt_q;

   assign full_o  = (cnt_q == CW'(DEPTH));
   assign empty_o = (cnt_q == '0);
   assign top_o   = mem_q[AW'(cnt_q - CW'(1))];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (push_i) begin
         mem_q[AW'(cnt_q)] <= data_i;
         cnt_q <= cnt_q + CW'(1);
      end else if (pop_i) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   a_r13_no_push_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_i |-> !full_o);

   a_r11_no_pop_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_i |-> !empty_o);

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
   import nest_irq_pkg::*;
#(
   parameter int unsigned NSRC = 8,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NSRC-1:0] req_i,
   input  logic [NSRC-1:0] prio_i,
   input  logic [NSRC-1:0] mask_i,
   input  logic            nmi_i,
   input  logic            boundary_i,
   input  logic            ei_i,
   input  logic            di_i,
   input  logic            reti_i,
   output logic            ack_o,
   output logic            ack_nmi_o,
   output logic [IW-1:0]   ack_idx_o,
   output logic            ien_o,
   output logic            isp_o
);

   if (NSRC < 2 || NSRC > 64) begin : g_bad_nsrc
      $error("nest_irq_ctrl: NSRC must lie in 2..64");
   end

   localparam int unsigned FW = $bits(irq_flags_t);

   logic [NSRC-1:0] pend_q, cand_hi, cand_lo, clr_vec;
   logic            nmi_q, nmi_pend_q, nmi_edge;
   irq_flags_t      flg_q, flg_d, st_top;
   logic [FW-1:0]   st_top_raw;
   logic            st_full, st_empty, arb_valid, arb_lo;
   logic [IW-1:0]   arb_idx;
   logic            window, take_nmi, take_msk, accept, do_pop;
   logic            ack_q, ack_nmi_q;
   logic [IW-1:0]   ack_idx_q;

   // eligibility: low-level sources need the in-service flag at 1
   assign cand_hi = pend_q & ~mask_i & ~prio_i;
   assign cand_lo = pend_q & ~mask_i & prio_i & {NSRC{flg_q.isp}};

   nest_irq_arb #(.NSRC(NSRC)) u_arb (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cand_hi_i (cand_hi),
      .cand_lo_i (cand_lo),
      .valid_o   (arb_valid),
      .idx_o     (arb_idx),
      .low_o     (arb_lo)
   );

   assign window   = boundary_i & ~reti_i & ~flg_q.nmi & ~st_full;
   assign take_nmi = window & nmi_pend_q;
   assign take_msk = window & ~nmi_pend_q & flg_q.ien & arb_valid;
   assign accept   = take_nmi | take_msk;
   assign do_pop   = reti_i & ~st_empty & ~accept;
   assign nmi_edge = nmi_i & ~nmi_q;

   always_comb begin
      clr_vec = '0;
      if (take_msk) clr_vec[arb_idx] = 1'b1;
   end

   nest_irq_stack #(.DEPTH(DEPTH), .W(FW)) u_stack (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (accept),
      .pop_i   (do_pop),
      .data_i  (flg_q),
      .top_o   (st_top_raw),
      .full_o  (st_full),
      .empty_o (st_empty)
   );
   assign st_top = st_top_raw;

   always_comb begin
      flg_d = flg_q;
      if (accept) begin
         flg_d.ien = 1'b0;
         if (take_nmi) flg_d.nmi = 1'b1;
         else          flg_d.isp = arb_lo;
      end else if (do_pop) begin
         flg_d = st_top;
      end else if (!reti_i) begin
         if (ei_i)      flg_d.ien = 1'b1;
         else if (di_i) flg_d.ien = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q     <= '0;
         nmi_q      <= 1'b0;
         nmi_pend_q <= 1'b0;
         flg_q      <= FLAGS_RST;
         ack_q      <= 1'b0;
         ack_nmi_q  <= 1'b0;
         ack_idx_q  <= '0;
      end else begin
         pend_q     <= (pend_q & ~clr_vec) | req_i;
         nmi_q      <= nmi_i;
         nmi_pend_q <= nmi_edge | (nmi_pend_q & ~take_nmi);
         flg_q      <= flg_d;
         ack_q      <= accept;
         ack_nmi_q  <= take_nmi;
         ack_idx_q  <= take_msk ? arb_idx : '0;
      end
   end

   assign ack_o     = ack_q;
   assign ack_nmi_o = ack_nmi_q;
   assign ack_idx_o = ack_idx_q;
   assign ien_o     = flg_q.ien;
   assign isp_o     = flg_q.isp;

   a_r4_accept_clears_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_o |-> !ien_o);

   a_r3_maskable_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_o && !ack_nmi_o) |-> $past(ien_o));

   a_r5_level_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_o && !ack_nmi_o) |-> isp_o == ((($past(prio_i) >> ack_idx_o) & NSRC'(1)) != '0));

   a_r9_nmi_keeps_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_o && ack_nmi_o) |-> isp_o == $past(isp_o));

   a_r10_nmi_blocks_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flg_q.nmi && boundary_i && !reti_i) |=> !ack_o);

   a_r12_no_take_on_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (boundary_i && reti_i) |=> !ack_o);

   a_r2_index_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_o |-> 32'(ack_idx_o) < NSRC);

endmodule

// File: tb/nest_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module nest_irq_ctrl_tb_top;

   localparam int NSRC = 8;
   localparam int DEPTH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NSRC-1:0] req = '0, prio = 8'b0010_1000, mask = '0;
   logic nmi = 1'b0, bnd_s = 1'b0, ei_s = 1'b0, di_s = 1'b0, reti_s = 1'b0;
   logic ack, ack_nmi, ien, isp;
   logic [2:0] ack_idx;

   int checks = 0;
   int errors = 0;
   int n_ack = 0;
   bit done = 1'b0;
   logic [3:0] exp_q[$];

   always #4 clk = ~clk;

   nest_irq_ctrl #(.NSRC(NSRC), .DEPTH(DEPTH)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .prio_i(prio), .mask_i(mask),
      .nmi_i(nmi), .boundary_i(bnd_s), .ei_i(ei_s), .di_i(di_s), .reti_i(reti_s),
      .ack_o(ack), .ack_nmi_o(ack_nmi), .ack_idx_o(ack_idx), .ien_o(ien), .isp_o(isp)
   );

   task automatic check(string tag, int got, int exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
      end
   endtask

   // monitor: compare every acknowledge against the scoreboard
   always @(negedge clk) begin
      if (rst_n && ack) begin
         n_ack++;
         if (exp_q.size() == 0) begin
            check("R2 unexpected ack", int'({ack_nmi, ack_idx}), -1);
         end else begin
            logic [3:0] e;
            e = exp_q.pop_front();
            check("R2/R7/R9 ack source", int'({ack_nmi, ack_idx}), int'(e));
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic raise(logic [NSRC-1:0] v);
      req = v; @(negedge clk); req = '0;
   endtask

   task automatic pulse_nmi();
      nmi = 1'b1; @(negedge clk); nmi = 1'b0; @(negedge clk);
   endtask

   task automatic strobe_ei();
      ei_s = 1'b1; @(negedge clk); ei_s = 1'b0;
   endtask

   task automatic strobe_di();
      di_s = 1'b1; @(negedge clk); di_s = 1'b0;
   endtask

   // boundary; expected acknowledges are queued beforehand
   task automatic bnd(string tag);
      bnd_s = 1'b1; @(negedge clk); bnd_s = 1'b0;
      @(negedge clk); #1;
      check(tag, exp_q.size(), 0);
   endtask

   task automatic retb(string tag);
      bnd_s = 1'b1; reti_s = 1'b1; @(negedge clk); bnd_s = 1'b0; reti_s = 1'b0;
      @(negedge clk); #1;
      check(tag, exp_q.size(), 0);
   endtask

   task automatic expect_ack(bit is_nmi, int idx);
      exp_q.push_back({is_nmi, 3'(idx)});
   endtask

   task automatic flags(string tag, int e_ien, int e_isp);
      check({tag, " enable"}, int'(ien), e_ien);
      check({tag, " level"}, int'(isp), e_isp);
   endtask

   initial begin
      int base;
      tick(3);
      #1;
      check("R1 ack after reset", int'(ack), 0);
      flags("R1 reset", 0, 1);
      rst_n = 1'b1;
      tick(2);

      // R3 refused while disabled, then accepted
      raise(8'h04);
      bnd("R3 no take with enable 0");
      strobe_ei();
      check("R3 ei sets enable", int'(ien), 1);
      expect_ack(0, 2);
      bnd("R3 take after ei");
      flags("R4/R5 high accept", 0, 0);

      // R6 nesting rules
      strobe_ei();
      raise(8'h20);
      bnd("R6 low refused under high");
      raise(8'h02);
      expect_ack(0, 1);
      bnd("R6 high nests on high");
      flags("R5 nested high", 0, 0);
      retb("R12 return boundary");
      flags("R11 first return", 1, 0);
      retb("R12 no take though low eligible");
      flags("R11 second return", 1, 1);
      expect_ack(0, 5);
      bnd("R12 take one boundary later");
      flags("R5 low accept", 0, 1);
      retb("R11 return from low");
      flags("R11 third return", 1, 1);
      strobe_di();
      retb("R11 empty return");
      flags("R11 empty return keeps", 0, 1);
      strobe_ei();

      // R7 arbitration
      raise(8'h58);
      expect_ack(0, 4);
      bnd("R7 lowest high index");
      retb("R7 ret");
      expect_ack(0, 6);
      bnd("R7 high beats lower-index low");
      retb("R7 ret");
      expect_ack(0, 3);
      bnd("R7 low last");
      retb("R7 ret");

      // R8 mask keeps latch
      mask = 8'h01;
      raise(8'h01);
      bnd("R8 masked not taken");
      check("R8 enable untouched", int'(ien), 1);
      mask = 8'h00;
      base = n_ack;
      tick(4);
      check("R2 no ack without boundary", n_ack, base);
      expect_ack(0, 0);
      bnd("R8 unmasked taken");
      retb("R8 ret");

      // R9/R10 non-maskable
      strobe_di();
      raise(8'h80);
      pulse_nmi();
      expect_ack(1, 0);
      bnd("R9 nmi with enable 0");
      flags("R9 nmi flags", 0, 1);
      strobe_ei();
      bnd("R10 no maskable during nmi");
      pulse_nmi();
      bnd("R10 no nmi during nmi");
      retb("R10 ret");
      flags("R11 after nmi return", 0, 1);
      expect_ack(1, 0);
      bnd("R9 second edge taken");
      retb("R9 ret");
      strobe_ei();
      expect_ack(0, 7);
      bnd("R9 pending maskable after nmi");
      retb("R9 ret");
      flags("R11 back to main", 1, 1);

      // R13 depth limit
      for (int k = 0; k < DEPTH; k++) begin
         raise(8'h02);
         expect_ack(0, 1);
         bnd("R13 fill");
         strobe_ei();
      end
      raise(8'h02);
      bnd("R13 full blocks maskable");
      pulse_nmi();
      bnd("R13 full blocks nmi");
      retb("R13 ret");
      flags("R11 pop from full", 1, 0);
      expect_ack(1, 0);
      bnd("R13 room again nmi taken");
      for (int k = 0; k < DEPTH; k++) retb("R13 unwind");
      flags("R11 unwound", 1, 1);
      expect_ack(0, 1);
      bnd("R13 held request taken");
      retb("R13 ret");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog got=timeout exp=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule